// File: doc/BRIEF.md
# Flash Access Timing Sequencer

This block times a single read or write access to an on-chip flash array. When a requester raises a request while the block is idle, the block runs a fixed sequence of strobes. First comes an address-transition pulse. A quiet gap follows, then an equalize pulse, and then a wait window. During the wait window a write drives the active-low write strobe. A completion pulse goes back to the requester. Before the block accepts the next request it holds a recovery interval, which keeps the write strobe high for a minimum time.

All logic runs on a timing clock at twice the bus rate, so one timing cycle is half a bus cycle. The three pulse widths (transition, gap, equalize) are programmed in half-bus-cycle steps. The wait and recovery times are programmed in whole bus cycles, which is two timing cycles each. When page mode is enabled and an access lands in the same page as the previous one, a separate and usually shorter page-hit wait replaces the normal wait. A 32-bit timing register and a 1-bit control register sit on a byte-enabled register port. Writing the transition-width field also copies its value into the gap field, unless the control register's hold bit is set.

Timing register layout (bit ranges; all other bits read 0):

| Bits  | Field     | Reset | Effect |
|-------|-----------|-------|--------|
| 29:28 | recov     | 3     | recovery H bus cycles: H = 5 when 3, else 2 + recov |
| 27:24 | wait_std  | 15    | normal wait, wait_std + 1 bus cycles |
| 22:20 | trans_w   | 7     | transition pulse, trans_w + 1 timing cycles |
| 19:16 | eqz_w     | 15    | equalize pulse, eqz_w + 1 timing cycles |
| 14:12 | gap_w     | 7     | gap, gap_w + 1 timing cycles |
| 11:8  | wait_pg   | 15    | page-hit wait, wait_pg + 1 bus cycles |
| 2:0   | pg_size   | 0     | 0 disables page mode; else page offset is pg_size + 2 address bits |

Top module: `flash_access_seq`

## Requirements
- R1: After reset the timing register reads 0x3F7F7F00, the control register reads 0, acc_ready is 1, addr_trans_o and equalize_o and acc_done are 0, and wr_en_n_o is 1.
- R2: addr_trans_o rises in the timing cycle after a request is accepted and stays high for trans_w + 1 timing cycles.
- R3: After addr_trans_o falls, both pulses stay low for gap_w + 1 timing cycles before equalize_o rises, and the two pulses never overlap.
- R4: equalize_o stays high for eqz_w + 1 timing cycles.
- R5: On a page miss, or when pg_size is 0, the wait window (from the fall of equalize_o to the rise of acc_done) lasts 2*(wait_std + 1) timing cycles. wr_en_n_o is 0 for the whole window on a write (acc_we = 1) and stays 1 on a read.
- R6: When pg_size is nonzero, a previous access has occurred since reset, and (acc_addr XOR previous address) shifted right by pg_size + 2 is zero, the wait window lasts 2*(wait_pg + 1) timing cycles.
- R7: acc_done is high for exactly 2 timing cycles, starting right after the wait window.
- R8: From the rise of acc_done to the return of acc_ready, 2*H timing cycles pass, with H = 5 when recov = 3 and H = 2 + recov otherwise; acc_done is low for the last 2*H - 2 of them.
- R9: A timing-register write with byte 2 enabled while the hold bit is 0 loads gap_w with the new trans_w value, even when byte 1 is enabled in the same write.
- R10: While the hold bit (control register bit 0, written with byte 0 enabled) is 1, a write that enables byte 2 leaves gap_w unchanged unless byte 1 is also enabled. A write that enables only byte 1 always sets gap_w from bits 14:12 and leaves trans_w unchanged.
- R11: Bits 31:30, 23, 15 and 7:3 of the timing register read 0 whatever is written to them.
- R12: A request is accepted only while acc_ready is 1. A request raised during an access has no effect, either on that access or after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | timing clock, twice the bus rate |
| rst | input | 1 | synchronous active-high reset |
| cfg_we | input | 1 | register write strobe |
| cfg_sel | input | 1 | 0 selects the timing register, 1 selects the control register |
| cfg_be | input | 4 | byte enables for the write |
| cfg_wdata | input | 32 | write data |
| cfg_rdata | output | 32 | registered read data for cfg_sel |
| acc_req | input | 1 | access request |
| acc_we | input | 1 | 1 for a write access |
| acc_addr | input | ADDR_W | access address, used for page-hit detection |
| acc_ready | output | 1 | idle; a request is accepted on this cycle |
| acc_done | output | 1 | access completion pulse |
| addr_trans_o | output | 1 | address-transition pulse to the array |
| equalize_o | output | 1 | equalize pulse to the array |
| wr_en_n_o | output | 1 | active-low write strobe |

## Verification
On every cycle the assertions check the ordering rules: a request seen while ready starts the transition pulse; the two pulses never overlap; the write strobe is low only while the block is busy; the completion pulse is two cycles long; and ready never returns straight after completion. The bench scenarios are the only place where the programmed widths are measured. They measure each phase length against the register values. They also cover page hit versus page miss, the copy from the transition field to the gap field with and without the hold bit, and a request raised during a busy access.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int CNT_W = 6;

  typedef struct packed {
    logic [1:0] recov;
    logic [3:0] wait_std;
    logic [2:0] trans_w;
    logic [3:0] eqz_w;
    logic [2:0] gap_w;
    logic [3:0] wait_pg;
    logic [2:0] pg_size;
  } tcfg_t;

  typedef enum logic [2:0] {
    S_IDLE, S_TRANS, S_GAP, S_EQZ, S_WAIT, S_DONE, S_REC
  } seq_st_t;

  localparam tcfg_t TCFG_RST = '{recov: 2'd3, wait_std: 4'd15, trans_w: 3'd7,
                                 eqz_w: 4'd15, gap_w: 3'd7, wait_pg: 4'd15,
                                 pg_size: 3'd0};

  function automatic logic [31:0] pack_tcfg(input tcfg_t c);
    return {2'b00, c.recov, c.wait_std, 1'b0, c.trans_w, c.eqz_w,
            1'b0, c.gap_w, c.wait_pg, 5'b00000, c.pg_size};
  endfunction

endpackage

// File: rtl/flash_cfg_regs.sv
module flash_cfg_regs
  import flash_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we,
  input  logic        sel,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output tcfg_t       tcfg,
  output logic [31:0] rdata
);

  logic hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      tcfg  <= TCFG_RST;
      hold  <= 1'b0;
      rdata <= '0;
    end else begin
      if (we && !sel) begin
        if (be[3]) begin
          tcfg.recov    <= wdata[29:28];
          tcfg.wait_std <= wdata[27:24];
        end
        if (be[2]) begin
          tcfg.trans_w <= wdata[22:20];
          tcfg.eqz_w   <= wdata[19:16];
        end
        // copy from the transition field wins over a direct gap write
        if (be[2] && !hold)
          tcfg.gap_w <= wdata[22:20];
        else if (be[1])
          tcfg.gap_w <= wdata[14:12];
        if (be[1]) tcfg.wait_pg <= wdata[11:8];
        if (be[0]) tcfg.pg_size <= wdata[2:0];
      end
      if (we && sel && be[0]) hold <= wdata[0];
      rdata <= sel ? {31'b0, hold} : pack_tcfg(tcfg);
    end
  end

endmodule

// File: rtl/flash_page_detect.sv
module flash_page_detect #(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BASE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        pg_size,
  output logic              hit
);

  logic [ADDR_W-1:0] last_addr;
  logic              last_vld;
  logic [ADDR_W-1:0] diff;

  always_comb begin
    diff = (addr ^ last_addr) >> (int'(pg_size) + PAGE_BASE);
    hit  = (pg_size != 3'd0) && last_vld && (diff == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_addr <= '0;
      last_vld  <= 1'b0;
    end else if (accept) begin
      last_addr <= addr;
      last_vld  <= 1'b1;
    end
  end

endmodule

// File: rtl/flash_strobe_fsm.sv
module flash_strobe_fsm
  import flash_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req,
  input  logic  we,
  input  logic  hit,
  input  tcfg_t tcfg,
  output logic  accept,
  output logic  ready_o,
  output logic  trans_o,
  output logic  eqz_o,
  output logic  done_o,
  output logic  wr_n_o
);

  seq_st_t          state, state_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic             we_q, hit_q;
  logic [3:0]       wsel;

  assign accept = (state == S_IDLE) && req;
  assign wsel   = hit_q ? tcfg.wait_pg : tcfg.wait_std;

  always_comb begin
    state_n = state;
    cnt_n   = (cnt == '0) ? cnt : cnt - 1'b1;
    unique case (state)
      S_IDLE:  if (req) begin state_n = S_TRANS; cnt_n = {3'b0, tcfg.trans_w}; end
      S_TRANS: if (cnt == '0) begin state_n = S_GAP; cnt_n = {3'b0, tcfg.gap_w}; end
      S_GAP:   if (cnt == '0) begin state_n = S_EQZ; cnt_n = {2'b0, tcfg.eqz_w}; end
      S_EQZ:   if (cnt == '0) begin state_n = S_WAIT; cnt_n = {1'b0, wsel, 1'b1}; end
      S_WAIT:  if (cnt == '0) begin state_n = S_DONE; cnt_n = 6'd1; end
      S_DONE:  if (cnt == '0) begin state_n = S_REC; cnt_n = {3'b0, tcfg.recov, 1'b1}; end
      S_REC:   if (cnt == '0) state_n = S_IDLE;
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      cnt     <= '0;
      we_q    <= 1'b0;
      hit_q   <= 1'b0;
      ready_o <= 1'b1;
      trans_o <= 1'b0;
      eqz_o   <= 1'b0;
      done_o  <= 1'b0;
      wr_n_o  <= 1'b1;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      if (accept) begin
        we_q  <= we;
        hit_q <= hit;
      end
      ready_o <= (state_n == S_IDLE);
      trans_o <= (state_n == S_TRANS);
      eqz_o   <= (state_n == S_EQZ);
      done_o  <= (state_n == S_DONE);
      wr_n_o  <= !((state_n == S_WAIT) && we_q);
    end
  end

endmodule

// File: rtl/flash_access_seq.sv
module flash_access_seq
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int PAGE_BASE = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [3:0]        cfg_be,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              acc_done,
  output logic              addr_trans_o,
  output logic              equalize_o,
  output logic              wr_en_n_o
);

  tcfg_t tcfg;
  logic  accept;
  logic  hit;

  flash_cfg_regs i_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .tcfg  (tcfg),
    .rdata (cfg_rdata)
  );

  flash_page_detect #(.ADDR_W(ADDR_W), .PAGE_BASE(PAGE_BASE)) i_page (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .addr    (acc_addr),
    .pg_size (tcfg.pg_size),
    .hit     (hit)
  );

  flash_strobe_fsm i_fsm (
    .clk     (clk),
    .rst     (rst),
    .req     (acc_req),
    .we      (acc_we),
    .hit     (hit),
    .tcfg    (tcfg),
    .accept  (accept),
    .ready_o (acc_ready),
    .trans_o (addr_trans_o),
    .eqz_o   (equalize_o),
    .done_o  (acc_done),
    .wr_n_o  (wr_en_n_o)
  );

endmodule

// File: rtl/flash_access_seq_chk.sv
module flash_access_seq_chk (
  input logic clk,
  input logic rst,
  input logic acc_req,
  input logic acc_ready,
  input logic acc_done,
  input logic addr_trans_o,
  input logic equalize_o,
  input logic wr_en_n_o
);

  p_accept_r12: assert property (@(posedge clk) disable iff (rst)
    acc_req && acc_ready |=> addr_trans_o && !acc_ready);

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
    acc_ready |-> !addr_trans_o && !equalize_o && wr_en_n_o && !acc_done);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    !(addr_trans_o && equalize_o));

  p_strobe_busy_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_en_n_o |-> !acc_ready && !acc_done && !equalize_o);

  p_done_two_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(acc_done) |=> acc_done);

  p_done_end_r7: assert property (@(posedge clk) disable iff (rst)
    acc_done && $past(acc_done) |=> !acc_done);

  p_recover_r8: assert property (@(posedge clk) disable iff (rst)
    acc_done |=> !acc_ready);

endmodule

bind flash_access_seq flash_access_seq_chk i_chk (.*);

// File: tb/test_flash_access_seq.sv
module test_flash_access_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_req = 1'b0, acc_we = 1'b0;
  logic [15:0] acc_addr = '0;
  logic        acc_ready, acc_done, addr_trans_o, equalize_o, wr_en_n_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // bench model of the register state
  logic [1:0] m_recov = 2'd3;
  logic [3:0] m_wstd = 4'd15, m_eq = 4'd15, m_wpg = 4'd15;
  logic [2:0] m_atd = 3'd7, m_gap = 3'd7, m_ps = 3'd0;
  logic       m_lock = 1'b0, m_valid = 1'b0;
  logic [15:0] m_last = '0;

  localparam logic [48:0] VECS [7] = '{
    {32'h0213_1100, 1'b0, 16'h0100},
    {32'h0213_1100, 1'b1, 16'h0104},
    {32'h1400_0001, 1'b0, 16'h0200},
    {32'h1400_0001, 1'b0, 16'h0204},
    {32'h2759_5302, 1'b1, 16'h0208},
    {32'h2759_5302, 1'b1, 16'h0310},
    {32'h3F7F_7F00, 1'b0, 16'h0000}
  };

  always #4 clk = ~clk;

  flash_access_seq i_flash_access_seq (.*);

  function automatic logic [31:0] m_pack();
    return {2'b00, m_recov, m_wstd, 1'b0, m_atd, m_eq, 1'b0, m_gap, m_wpg, 5'b0, m_ps};
  endfunction

  task automatic check(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", what, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
    if (sel) begin
      if (be[0]) m_lock = d[0];
    end else begin
      if (be[3]) begin m_recov = d[29:28]; m_wstd = d[27:24]; end
      if (be[2]) begin m_atd = d[22:20]; m_eq = d[19:16]; end
      if (be[2] && !m_lock) m_gap = d[22:20];
      else if (be[1]) m_gap = d[14:12];
      if (be[1]) m_wpg = d[11:8];
      if (be[0]) m_ps = d[2:0];
    end
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk);
    cfg_sel = sel;
    @(negedge clk);
    v = cfg_rdata;
  endtask

  task automatic access(input logic we, input logic [15:0] addr, input bit poke);
    int ph = 0, k = 0;
    int n_atd = 0, n_gap = 0, n_eq = 0, n_wait = 0, n_wl = 0, n_done = 0, n_rec = 0;
    bit hit;
    int w, h;
    hit = (m_ps != 0) && m_valid && (((addr ^ m_last) >> (m_ps + 2)) == 0);
    w = hit ? int'(m_wpg) : int'(m_wstd);
    h = (m_recov == 2'd3) ? 5 : 2 + int'(m_recov);
    m_last = addr; m_valid = 1'b1;
    @(negedge clk);
    acc_req = 1'b1; acc_we = we; acc_addr = addr;
    @(negedge clk);
    acc_req = 1'b0;
    while (ph != 6 && k < 1000) begin
      if (ph == 0 && !addr_trans_o) ph = 1;
      if (ph == 1 && equalize_o) ph = 2;
      if (ph == 2 && !equalize_o) ph = 3;
      if (ph == 3 && acc_done) ph = 4;
      if (ph == 4 && !acc_done) ph = 5;
      if (ph == 5 && acc_ready) ph = 6;
      case (ph)
        0: n_atd++;
        1: n_gap++;
        2: n_eq++;
        3: begin n_wait++; if (!wr_en_n_o) n_wl++; end
        4: n_done++;
        5: n_rec++;
        default: ;
      endcase
      if (poke && k == 3) acc_req = 1'b1;
      if (poke && k == 4) acc_req = 1'b0;
      k++;
      @(negedge clk);
    end
    check("R12 access completes", ph, 6);
    check("R2 transition width", n_atd, int'(m_atd) + 1);
    check("R3 gap width", n_gap, int'(m_gap) + 1);
    check("R4 equalize width", n_eq, int'(m_eq) + 1);
    check(hit ? "R6 page-hit wait" : "R5 normal wait", n_wait, 2 * (w + 1));
    check("R5 write strobe low", n_wl, we ? 2 * (w + 1) : 0);
    check("R7 done width", n_done, 2);
    check("R8 recovery", n_rec, 2 * h - 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R7 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", acc_ready, 1);
    check("R1 pulses idle", {addr_trans_o, equalize_o, acc_done, wr_en_n_o}, 4'b0001);
    rd(1'b0, v); check("R1 timing reg reset", v, 32'h3F7F_7F00);
    rd(1'b1, v); check("R1 control reg reset", v, 0);

    // table walk: full register writes then one access each
    foreach (VECS[i]) begin
      wr(1'b0, 4'hF, VECS[i][48:17]);
      rd(1'b0, v); check("R11 readback", v, m_pack());
      access(VECS[i][16], VECS[i][15:0], 1'b0);
    end

    // reserved and unused bits
    wr(1'b0, 4'hF, 32'hFFFF_FFFF);
    rd(1'b0, v); check("R11 reserved bits zero", v, 32'h3F7F_7F07);

    // auto copy overrides a direct gap write in the same access
    wr(1'b0, 4'b0110, 32'h0026_6000);
    rd(1'b0, v); check("R9 gap copied from transition", v[14:12], 2);
    access(1'b0, 16'h1000, 1'b0);

    // byte-1-only write sets gap alone
    wr(1'b0, 4'b0010, 32'h0000_4000);
    rd(1'b0, v); check("R10 gap direct write", v[14:12], 4);
    check("R10 transition unchanged", v[22:20], 2);
    wr(1'b1, 4'b0001, 32'h1);
    rd(1'b1, v); check("R10 hold bit set", v, 1);
    wr(1'b0, 4'b0100, 32'h0060_0000);
    rd(1'b0, v); check("R10 held gap kept", v[14:12], 4);
    check("R10 transition written", v[22:20], 6);
    wr(1'b0, 4'b0110, 32'h0010_3000);
    rd(1'b0, v); check("R10 held gap from byte 1", v[14:12], 3);
    access(1'b1, 16'h2000, 1'b0);

    // request raised while busy is ignored
    access(1'b0, 16'h3000, 1'b1);
    repeat (4) begin
      @(negedge clk);
      check("R12 busy request ignored", {acc_ready, addr_trans_o}, 2'b10);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule